// File: doc/BRIEF.md
# Address Collision Busy Arbiter

This block sits beside the storage array of a two-port memory and watches the enable and address of both ports every cycle. When both ports reach the same word at once, it decides which port keeps the word and raises a busy flag on the other port. The flagged port's write strobe is suppressed before it reaches the array. A read on the flagged port is not stopped, but the busy flag tells the reader that the data may still be changing.

A mode input selects how the busy flags behave. With the mode input high (master), the block runs the arbitration itself and drives both busy outputs. With the mode input low (slave), the busy outputs stay low. The block then takes the busy flags from another device's outputs and uses them only to suppress writes. Several memories placed side by side for a wider word then refuse the same write in the same cycle, so every slice of the wide word agrees.

Top module: `collision_busy_arbiter`

## Requirements
- R1: After reset, and in any cycle with no collision in master mode, both busy outputs are low. Every enabled write with write-enable high produces a write strobe.
- R2: A collision exists only when both port enables are high and the two addresses are equal in every bit. Addresses that differ in any single bit, including the top bit, cause no busy.
- R3: An access starts in a cycle where the port is enabled and, in the previous cycle, it was either disabled or at a different address. When a port that started earlier collides with a port that starts now, the newly started port is flagged busy.
- R4: When both ports start an access to the same address in the same cycle, the right port is flagged busy and the left port wins. The same applies in the first cycle after reset.
- R5: While both ports stay enabled at the same unchanged address, the busy flag stays on the same port from cycle to cycle.
- R6: Busy drops in the same cycle in which the winning port drops its enable or moves to another address.
- R7: In master mode, a port whose busy output is high gets no write strobe, while the other port writes normally. The busy inputs have no effect in master mode.
- R8: In slave mode, both busy outputs are held low, and each port's write strobe is suppressed exactly while that port's busy input is high.
- R9: In slave mode, a same-address access by both ports with both busy inputs low lets both writes through.
- R10: Read accesses (write-enable low) take part in collisions in the same way as writes, so a port reading a word the other port holds is flagged busy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| masterMode | input | 1 | 1 = compute and drive busy; 0 = take busy from inputs |
| leftEn | input | 1 | Left port enable |
| leftWe | input | 1 | Left port write enable |
| leftAddr | input | ADDR_W | Left port word address |
| rightEn | input | 1 | Right port enable |
| rightWe | input | 1 | Right port write enable |
| rightAddr | input | ADDR_W | Right port word address |
| leftBusyIn | input | 1 | External busy for the left port (used in slave mode) |
| rightBusyIn | input | 1 | External busy for the right port (used in slave mode) |
| leftBusyOut | output | 1 | Left port busy flag (master mode) |
| rightBusyOut | output | 1 | Right port busy flag (master mode) |
| leftWriteGo | output | 1 | Left write strobe to the array |
| rightWriteGo | output | 1 | Right write strobe to the array |

## Verification
The two functions that can meet in one cycle are the arbitration decision and the write suppression. A port can be flagged busy in the same cycle in which it asserts write-enable, and the strobe must be cut in that cycle, not the next. The bench provokes this by starting a write on one port at the address the other port already holds. It also holds a collision while the loser toggles between read and write. In each cycle it checks both the busy outputs and the write strobes, against values worked out from the start rules. Slave cycles drive the external busy inputs against an internal collision, to confirm that only the inputs govern the strobes there.

// File: rtl/arb_pkg.sv
package arb_pkg;

  typedef enum logic [1:0] {
    W_NONE  = 2'd0,
    W_LEFT  = 2'd1,
    W_RIGHT = 2'd2
  } winner_e;

  localparam int NUM_PORTS = 2;
  localparam int P_LEFT    = 0;
  localparam int P_RIGHT   = 1;

  // datapath -> control: compare results
  typedef struct packed {
    logic                 collide;
    logic [NUM_PORTS-1:0] start;
  } cmpStatus_t;

  // control -> datapath: write inhibit strobes
  typedef struct packed {
    logic [NUM_PORTS-1:0] blk;
  } inhibit_t;

endpackage

// File: rtl/arb_datapath.sv
module arb_datapath
  import arb_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              leftEn,
  input  logic              leftWe,
  input  logic [ADDR_W-1:0] leftAddr,
  input  logic              rightEn,
  input  logic              rightWe,
  input  logic [ADDR_W-1:0] rightAddr,
  input  inhibit_t          inhibit,
  output cmpStatus_t        status,
  output logic              leftWriteGo,
  output logic              rightWriteGo
);

  logic [NUM_PORTS-1:0] portEn;
  logic [NUM_PORTS-1:0] portWe;
  logic [ADDR_W-1:0]    portAddr [NUM_PORTS];
  logic [NUM_PORTS-1:0] startVec;
  logic [NUM_PORTS-1:0] goVec;

  assign portEn[P_LEFT]    = leftEn;
  assign portEn[P_RIGHT]   = rightEn;
  assign portWe[P_LEFT]    = leftWe;
  assign portWe[P_RIGHT]   = rightWe;
  assign portAddr[P_LEFT]  = leftAddr;
  assign portAddr[P_RIGHT] = rightAddr;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic              enQ;
    logic [ADDR_W-1:0] addrQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        enQ   <= 1'b0;
        addrQ <= '0;
      end else begin
        enQ   <= portEn[p];
        addrQ <= portAddr[p];
      end
    end

    // a fresh access: enabled now, and idle or elsewhere last cycle
    assign startVec[p] = portEn[p] && !(enQ && (addrQ == portAddr[p]));
    assign goVec[p]    = portEn[p] && portWe[p] && !inhibit.blk[p];
  end

  assign status.collide = leftEn && rightEn && (leftAddr == rightAddr);
  assign status.start   = startVec;
  assign leftWriteGo    = goVec[P_LEFT];
  assign rightWriteGo   = goVec[P_RIGHT];

endmodule

// File: rtl/arb_control.sv
module arb_control
  import arb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       masterMode,
  input  cmpStatus_t status,
  input  logic       leftBusyIn,
  input  logic       rightBusyIn,
  output logic       leftBusyOut,
  output logic       rightBusyOut,
  output inhibit_t   inhibit
);

  winner_e              winnerQ;
  winner_e              winnerD;
  logic [NUM_PORTS-1:0] masterBusy;
  logic [NUM_PORTS-1:0] slaveBusy;

  always_comb begin
    winnerD = W_NONE;
    if (status.collide) begin
      unique case (status.start)
        2'b00:   winnerD = (winnerQ == W_RIGHT) ? W_RIGHT : W_LEFT;
        2'b01:   winnerD = W_RIGHT;  // left fresh, right held
        2'b10:   winnerD = W_LEFT;   // right fresh, left held
        default: winnerD = W_LEFT;   // tie goes left
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) winnerQ <= W_NONE;
    else       winnerQ <= winnerD;
  end

  assign masterBusy[P_LEFT]  = (winnerD == W_RIGHT);
  assign masterBusy[P_RIGHT] = (winnerD == W_LEFT);
  assign slaveBusy[P_LEFT]   = leftBusyIn;
  assign slaveBusy[P_RIGHT]  = rightBusyIn;

  assign inhibit.blk  = masterMode ? masterBusy : slaveBusy;
  assign leftBusyOut  = masterMode && masterBusy[P_LEFT];
  assign rightBusyOut = masterMode && masterBusy[P_RIGHT];

endmodule

// File: rtl/collision_busy_arbiter.sv
module collision_busy_arbiter
  import arb_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              masterMode,
  input  logic              leftEn,
  input  logic              leftWe,
  input  logic [ADDR_W-1:0] leftAddr,
  input  logic              rightEn,
  input  logic              rightWe,
  input  logic [ADDR_W-1:0] rightAddr,
  input  logic              leftBusyIn,
  input  logic              rightBusyIn,
  output logic              leftBusyOut,
  output logic              rightBusyOut,
  output logic              leftWriteGo,
  output logic              rightWriteGo
);

  cmpStatus_t status;
  inhibit_t   inhibit;

  arb_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .leftEn      (leftEn),
    .leftWe      (leftWe),
    .leftAddr    (leftAddr),
    .rightEn     (rightEn),
    .rightWe     (rightWe),
    .rightAddr   (rightAddr),
    .inhibit     (inhibit),
    .status      (status),
    .leftWriteGo (leftWriteGo),
    .rightWriteGo(rightWriteGo)
  );

  arb_control u_ctl (
    .clk         (clk),
    .rstN        (rstN),
    .masterMode  (masterMode),
    .status      (status),
    .leftBusyIn  (leftBusyIn),
    .rightBusyIn (rightBusyIn),
    .leftBusyOut (leftBusyOut),
    .rightBusyOut(rightBusyOut),
    .inhibit     (inhibit)
  );

endmodule

// File: rtl/arb_checker.sv
module arb_checker #(
  parameter int ADDR_W = 14
) (
  input logic              clk,
  input logic              rstN,
  input logic              masterMode,
  input logic              leftEn,
  input logic              leftWe,
  input logic [ADDR_W-1:0] leftAddr,
  input logic              rightEn,
  input logic              rightWe,
  input logic [ADDR_W-1:0] rightAddr,
  input logic              leftBusyIn,
  input logic              rightBusyIn,
  input logic              leftBusyOut,
  input logic              rightBusyOut,
  input logic              leftWriteGo,
  input logic              rightWriteGo
);

  logic sameWord;
  assign sameWord = leftEn && rightEn && (leftAddr == rightAddr);

  // R2
  busy_needs_collision_chk: assert property (@(posedge clk) disable iff (!rstN)
    (leftBusyOut || rightBusyOut) |-> sameWord);

  // R4
  single_loser_chk: assert property (@(posedge clk) disable iff (!rstN)
    (masterMode && sameWord) |-> ($countones({leftBusyOut, rightBusyOut}) == 1));

  // R5
  hold_loser_chk: assert property (@(posedge clk) disable iff (!rstN)
    (masterMode && sameWord && $past(masterMode) && $past(sameWord)
     && $stable(leftAddr) && $stable(rightAddr)) |-> ($stable(leftBusyOut) && $stable(rightBusyOut)));

  // R7
  master_write_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    masterMode |-> (leftWriteGo == (leftEn && leftWe && !leftBusyOut))
                && (rightWriteGo == (rightEn && rightWe && !rightBusyOut)));

  // R8
  slave_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !masterMode |-> (!leftBusyOut && !rightBusyOut));

  // R8
  slave_write_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !masterMode |-> (leftWriteGo == (leftEn && leftWe && !leftBusyIn))
                 && (rightWriteGo == (rightEn && rightWe && !rightBusyIn)));

endmodule

bind collision_busy_arbiter arb_checker #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_collision_busy_arbiter.sv
module sim_collision_busy_arbiter;

  localparam int CLK_PER = 10;
  localparam int AW      = 14;
  localparam int NV      = 16;

  typedef struct packed {
    logic          mst;
    logic          lEn;
    logic          lWe;
    logic [AW-1:0] lA;
    logic          rEn;
    logic          rWe;
    logic [AW-1:0] rA;
    logic          lBi;
    logic          rBi;
    logic          eLBo;
    logic          eRBo;
    logic          eLGo;
    logic          eRGo;
    logic [7:0]    req;
  } vec_t;

  // mst lEn lWe lA rEn rWe rA lBi rBi | eLBo eRBo eLGo eRGo | req
  localparam vec_t VEC [NV] = '{
    '{1'b1,1'b0,1'b0,14'd0, 1'b0,1'b0,14'd0, 1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0, 8'd1},  // R1 idle
    '{1'b1,1'b1,1'b1,14'd5, 1'b1,1'b1,14'd6, 1'b0,1'b0, 1'b0,1'b0,1'b1,1'b1, 8'd2},  // R2 diff addr
    '{1'b1,1'b1,1'b1,14'd5, 1'b1,1'b1,14'd5, 1'b0,1'b0, 1'b0,1'b1,1'b1,1'b0, 8'd3},  // R3 right fresh
    '{1'b1,1'b1,1'b1,14'd5, 1'b1,1'b1,14'd5, 1'b0,1'b0, 1'b0,1'b1,1'b1,1'b0, 8'd5},  // R5 hold
    '{1'b1,1'b0,1'b1,14'd5, 1'b1,1'b1,14'd5, 1'b0,1'b0, 1'b0,1'b0,1'b0,1'b1, 8'd6},  // R6 winner off
    '{1'b1,1'b1,1'b1,14'd5, 1'b1,1'b1,14'd5, 1'b0,1'b0, 1'b1,1'b0,1'b0,1'b1, 8'd3},  // R3 left fresh
    '{1'b1,1'b0,1'b0,14'd0, 1'b0,1'b0,14'd0, 1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0, 8'd1},  // R1 idle
    '{1'b1,1'b1,1'b1,14'd9, 1'b1,1'b1,14'd9, 1'b0,1'b0, 1'b0,1'b1,1'b1,1'b0, 8'd4},  // R4 tie
    '{1'b1,1'b1,1'b1,14'd10,1'b1,1'b1,14'd9, 1'b0,1'b0, 1'b0,1'b0,1'b1,1'b1, 8'd6},  // R6 winner moves
    '{1'b1,1'b0,1'b0,14'd0, 1'b0,1'b0,14'd0, 1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0, 8'd1},  // R1 idle
    '{1'b1,1'b1,1'b0,14'd3, 1'b1,1'b0,14'd3, 1'b0,1'b0, 1'b0,1'b1,1'b0,1'b0, 8'd10}, // R10 reads
    '{1'b1,1'b1,1'b0,14'd3, 1'b1,1'b1,14'd3, 1'b0,1'b0, 1'b0,1'b1,1'b0,1'b0, 8'd7},  // R7 loser write cut
    '{1'b0,1'b1,1'b1,14'd3, 1'b1,1'b1,14'd3, 1'b0,1'b0, 1'b0,1'b0,1'b1,1'b1, 8'd9},  // R9 slave both go
    '{1'b0,1'b1,1'b1,14'd3, 1'b1,1'b1,14'd3, 1'b1,1'b0, 1'b0,1'b0,1'b0,1'b1, 8'd8},  // R8 left inhibited
    '{1'b0,1'b1,1'b1,14'd3, 1'b1,1'b1,14'd3, 1'b0,1'b1, 1'b0,1'b0,1'b1,1'b0, 8'd8},  // R8 right inhibited
    '{1'b1,1'b1,1'b1,14'd1, 1'b0,1'b0,14'd0, 1'b1,1'b1, 1'b0,1'b0,1'b1,1'b0, 8'd7}   // R7 inputs ignored
  };

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          masterMode = 1'b1;
  logic          leftEn = 1'b0, leftWe = 1'b0, rightEn = 1'b0, rightWe = 1'b0;
  logic [AW-1:0] leftAddr = '0, rightAddr = '0;
  logic          leftBusyIn = 1'b0, rightBusyIn = 1'b0;
  logic          leftBusyOut, rightBusyOut, leftWriteGo, rightWriteGo;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #(CLK_PER/2) clk = ~clk;

  collision_busy_arbiter #(.ADDR_W(AW)) u0 (
    .clk(clk), .rstN(rstN), .masterMode(masterMode),
    .leftEn(leftEn), .leftWe(leftWe), .leftAddr(leftAddr),
    .rightEn(rightEn), .rightWe(rightWe), .rightAddr(rightAddr),
    .leftBusyIn(leftBusyIn), .rightBusyIn(rightBusyIn),
    .leftBusyOut(leftBusyOut), .rightBusyOut(rightBusyOut),
    .leftWriteGo(leftWriteGo), .rightWriteGo(rightWriteGo)
  );

  task automatic check4(input int req, input string what, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL R%0d %s: {lBusy,rBusy,lGo,rGo} actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic m, input logic le, input logic lw, input logic [AW-1:0] la,
                       input logic re, input logic rw, input logic [AW-1:0] ra,
                       input logic lb, input logic rb);
    masterMode = m; leftEn = le; leftWe = lw; leftAddr = la;
    rightEn = re; rightWe = rw; rightAddr = ra; leftBusyIn = lb; rightBusyIn = rb;
  endtask

  function automatic logic [3:0] outs();
    return {leftBusyOut, rightBusyOut, leftWriteGo, rightWriteGo};
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not finish actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1: state during and after reset
    repeat (2) @(negedge clk);
    #1 check4(1, "in reset", outs(), 4'b0000);
    rstN = 1'b1;
    @(negedge clk);
    drive(1'b1, 1'b1, 1'b1, 14'd20, 1'b0, 1'b0, 14'd0, 1'b0, 1'b0);
    #1 check4(1, "after reset lone write", outs(), 4'b0010);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i].mst, VEC[i].lEn, VEC[i].lWe, VEC[i].lA, VEC[i].rEn, VEC[i].rWe, VEC[i].rA,
            VEC[i].lBi, VEC[i].rBi);
      #1 check4(int'(VEC[i].req), $sformatf("vector %0d", i), outs(),
                {VEC[i].eLBo, VEC[i].eRBo, VEC[i].eLGo, VEC[i].eRGo});
    end

    // R2: addresses differing only in top bit do not collide
    @(negedge clk);
    drive(1'b1, 1'b1, 1'b1, 14'h2007, 1'b1, 1'b1, 14'h0007, 1'b0, 1'b0);
    #1 check4(2, "top bit differs", outs(), 4'b0011);

    // R3: right holds addr 7, left arrives later and loses
    @(negedge clk);
    drive(1'b1, 1'b0, 1'b0, 14'd0, 1'b1, 1'b1, 14'd7, 1'b0, 1'b0);
    @(negedge clk);
    drive(1'b1, 1'b1, 1'b1, 14'd7, 1'b1, 1'b1, 14'd7, 1'b0, 1'b0);
    #1 check4(3, "late left loses", outs(), 4'b1001);

    // R4: reset while collision held; afterwards both count as fresh, left wins
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    #1 check4(4, "tie after reset", outs(), 4'b0110);
    // R5: held on the next cycle
    @(negedge clk);
    #1 check4(5, "hold after reset", outs(), 4'b0110);

    // R6: winner (left) moves, right then free
    @(negedge clk);
    drive(1'b1, 1'b1, 1'b1, 14'd8, 1'b1, 1'b1, 14'd7, 1'b0, 1'b0);
    #1 check4(6, "left moved away", outs(), 4'b0011);

    @(negedge clk);
    drive(1'b1, 1'b0, 1'b0, 14'd0, 1'b0, 1'b0, 14'd0, 1'b0, 1'b0);
    #1 check4(1, "final idle", outs(), 4'b0000);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule